// File: doc/BRIEF.md
# Bit-Slip Word Aligner with Pattern Detector

This block sits behind a deserializer and re-frames its stream of parallel words onto a word boundary that only the user moves. It keeps the previous input word and the current one, and a barrel shifter picks a word-wide window across the two. Each accepted slip request moves that window one bit earlier in the serial stream. The offset counts from 0 to DW-1 and then wraps back to 0. DW is the word width: the symbol width (8 or 10) in single-width builds, and twice that in double-width builds.

A comparator watches the aligned words while slips are in progress. It can match one programmable word, such as a two-byte framing pair in a 16-bit build. It can also match two programmable words in a row, such as a doubled framing sequence split over two 16-bit words. It reports a match through a registered flag that is aligned with the output word that completes the pattern. There is no automatic synchronization. The user drives the slip input until the flag appears.

Top module: `bitslip_aligner`

## Requirements
- R1: The serial bit order is LSB first. At slip offset k, output bit j is bit j-k of the current input word when j >= k. Otherwise it is bit DW+j-k of the previous input word. The output is registered one cycle after the input word, so at offset 0 it repeats the input word one cycle later.
- R2: While `rst` is high, at the next clock edge the offset returns to 0, `dout` becomes 0, `pat_hit` becomes 0 and the stored previous word becomes 0. This holds for reset at start-up and for reset in the middle of a run.
- R3: A rising edge on `slip_req` that is accepted at a clock edge raises the offset by one. The new offset applies to the output word loaded at the following edge.
- R4: A `slip_req` held high for many cycles gives exactly one slip.
- R5: After an accepted slip, a rising edge of `slip_req` that is sampled at either of the next SLIP_HOLD (default 2) clock edges is ignored. A rising edge after that window is accepted.
- R6: A slip taken at offset DW-1 returns the offset to 0, so DW slips restore the original framing.
- R7: With `cfg_two_word` low, `pat_hit` is high in exactly the cycles where `dout` equals `cfg_pattern[DW-1:0]`. It falls in the first cycle whose word does not match.
- R8: With `cfg_two_word` high, `pat_hit` is high in the cycle where `dout` equals `cfg_pattern[2*DW-1:DW]` and the previous output word equalled `cfg_pattern[DW-1:0]`. The first output word after reset never completes a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive parallel clock |
| rst | input | 1 | Active-high synchronous reset |
| din | input | DW | Deserialized word, earliest bit in bit 0 |
| slip_req | input | 1 | User request to slip the boundary by one bit (rising edge) |
| cfg_pattern | input | 2*DW | Pattern words; low half is the first word, high half the second |
| cfg_two_word | input | 1 | 0: match one word; 1: match the two-word sequence |
| dout | output | DW | Re-framed output word |
| pat_hit | output | 1 | Registered pattern match, aligned with `dout` |

## Verification
The slip offset is the only hidden state that matters. If it is wrong, every later output word is wrong: it shows up as a rotation of a constant input one cycle after the faulty slip edge. The bench therefore holds the input constant or periodic and compares every output word against a model of the offset. A lost or doubled slip, a lockout window that is too short or too long, or a missing wrap each leave a persistent rotation that the next comparison reports. A mistake in the detector's memory of the previous word only shows in two-word mode, on the word that should complete the pair.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic {
    MATCH_ONE = 1'b0,
    MATCH_TWO = 1'b1
  } match_mode_e;

  // Next slip offset within a span of positions, wrapping to zero.
  function automatic int unsigned bump_offset(input int unsigned cur,
                                              input int unsigned span);
    return (cur + 1 >= span) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/bsa_slip_ctrl.sv
module bsa_slip_ctrl #(
  parameter int DW    = 16,
  parameter int HOLD  = 2,
  localparam int OFF_W  = (DW > 1) ? $clog2(DW) : 1,
  localparam int HOLD_W = $clog2(HOLD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slip_req,
  output logic [OFF_W-1:0] off_o,
  output logic             accept_o
);
  import bsa_pkg::*;

  logic              slip_d_q;
  logic [HOLD_W-1:0] hold_q;
  logic [OFF_W-1:0]  off_q;
  logic              slip_rise;
  logic              accept;

  assign slip_rise = slip_req & ~slip_d_q;
  assign accept    = slip_rise & (hold_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slip_d_q <= 1'b0;
      hold_q   <= '0;
      off_q    <= '0;
    end else begin
      slip_d_q <= slip_req;
      if (accept) begin
        hold_q <= HOLD_W'(HOLD);
        off_q  <= OFF_W'(bump_offset(32'(off_q), DW));
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end

  assign off_o    = off_q;
  assign accept_o = accept;

  // R6
  offset_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(off_q) < DW);

  // R3
  offset_step_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (32'(off_q) == ((32'($past(off_q)) + 1) % DW)));

  // R4
  offset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(off_q));

  // R5
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);

endmodule

// File: rtl/bsa_shifter.sv
module bsa_shifter #(
  parameter int DW = 16,
  localparam int OFF_W = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    din,
  input  logic [OFF_W-1:0] off_i,
  output logic [DW-1:0]    win_o,
  output logic [DW-1:0]    dout_o
);

  // Window that starts k bits before the first bit of the current word.
  function automatic logic [DW-1:0] window_at(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] prev,
                                              input int k);
    logic [2*DW-1:0] pair;
    pair = {cur, prev};
    return pair[(DW - k) +: DW];
  endfunction

  logic [DW-1:0] hist_q;
  logic [DW-1:0] dout_q;
  logic [DW-1:0] cand [DW];
  logic [DW-1:0] win;

  for (genvar g = 0; g < DW; g++) begin : g_cand
    assign cand[g] = window_at(din, hist_q, g);
  end

  always_comb begin
    win = cand[0];
    for (int g = 1; g < DW; g++) begin
      if (32'(off_i) == g) win = cand[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      dout_q <= '0;
    end else begin
      hist_q <= din;
      dout_q <= win;
    end
  end

  assign win_o  = win;
  assign dout_o = dout_q;

  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(off_i) == '0) |-> (dout_q == $past(din)));

endmodule

// File: rtl/bsa_pat_det.sv
module bsa_pat_det #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   win_i,
  input  logic [DW-1:0]   last_i,
  input  logic [2*DW-1:0] cfg_pattern,
  input  bsa_pkg::match_mode_e mode_i,
  output logic            hit_o
);
  import bsa_pkg::*;

  logic          first_q;
  logic          hit_q;
  logic          match_one;
  logic          match_two;
  logic [DW-1:0] pat_lo;
  logic [DW-1:0] pat_hi;

  assign pat_lo    = cfg_pattern[DW-1:0];
  assign pat_hi    = cfg_pattern[2*DW-1:DW];
  assign match_one = (win_i == pat_lo);
  assign match_two = first_q && (last_i == pat_lo) && (win_i == pat_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      first_q <= 1'b1;
      hit_q   <= (mode_i == MATCH_TWO) ? match_two : match_one;
    end
  end

  assign hit_o = hit_q;

endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
  parameter int SYM_W     = 8,
  parameter bit DOUBLE    = 1'b1,
  parameter int SLIP_HOLD = 2,
  localparam int DW    = DOUBLE ? 2 * SYM_W : SYM_W,
  localparam int OFF_W = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   din,
  input  logic            slip_req,
  input  logic [2*DW-1:0] cfg_pattern,
  input  logic            cfg_two_word,
  output logic [DW-1:0]   dout,
  output logic            pat_hit
);
  import bsa_pkg::*;

  logic [OFF_W-1:0] slip_off;
  logic             slip_taken;
  logic [DW-1:0]    aligned_win;
  match_mode_e      det_mode;

  assign det_mode = cfg_two_word ? MATCH_TWO : MATCH_ONE;

  bsa_slip_ctrl #(.DW(DW), .HOLD(SLIP_HOLD)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .slip_req (slip_req),
    .off_o    (slip_off),
    .accept_o (slip_taken)
  );

  bsa_shifter #(.DW(DW)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .off_i  (slip_off),
    .win_o  (aligned_win),
    .dout_o (dout)
  );

  bsa_pat_det #(.DW(DW)) u_det (
    .clk         (clk),
    .rst         (rst),
    .win_i       (aligned_win),
    .last_i      (dout),
    .cfg_pattern (cfg_pattern),
    .mode_i      (det_mode),
    .hit_o       (pat_hit)
  );

  // R7
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (pat_hit && !$past(cfg_two_word)) |-> (dout == $past(cfg_pattern[DW-1:0])));

  // R8
  pair_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (pat_hit && $past(cfg_two_word)) |->
      (dout == $past(cfg_pattern[2*DW-1:DW]) &&
       $past(dout) == $past(cfg_pattern[DW-1:0])));

endmodule

// File: tb/bitslip_aligner_tb.sv
module bitslip_aligner_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic          slip = 1'b0;
  logic [2*DW-1:0] cfg_pattern = '0;
  logic          cfg_two = 1'b0;
  logic [DW-1:0] dout;
  logic          pat_hit;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  int            m_off, m_hold;
  bit            m_sd, m_first;
  logic [DW-1:0] m_prev, m_out;

  always #4 clk = ~clk;

  bitslip_aligner #(.SYM_W(8), .DOUBLE(1'b1), .SLIP_HOLD(2)) dut_i (
    .clk(clk), .rst(rst), .din(din), .slip_req(slip),
    .cfg_pattern(cfg_pattern), .cfg_two_word(cfg_two),
    .dout(dout), .pat_hit(pat_hit)
  );

  function automatic logic [DW-1:0] rotl(input logic [DW-1:0] v, input int k);
    logic [DW-1:0] r = v;
    for (int i = 0; i < k; i++) r = {r[DW-2:0], r[DW-1]};
    return r;
  endfunction

  function automatic logic [DW-1:0] model_pick(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] prev,
                                               input int k);
    if (k == 0) return cur;
    return (cur << k) | (prev >> (DW - k));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_off = 0; m_hold = 0; m_sd = 0; m_first = 0; m_prev = '0; m_out = '0;
  endtask

  // One clock: drive, step, compare with the model.
  task automatic cyc(input logic [DW-1:0] d, input bit s, input string req);
    logic [DW-1:0] e;
    bit eh;
    din = d; slip = s;
    @(posedge clk); @(negedge clk);
    e = model_pick(d, m_prev, m_off);
    if (cfg_two) eh = m_first && (m_out == cfg_pattern[DW-1:0]) && (e == cfg_pattern[2*DW-1:DW]);
    else         eh = (e == cfg_pattern[DW-1:0]);
    m_prev = d; m_out = e; m_first = 1;
    if (s && !m_sd && m_hold == 0) begin
      m_off = (m_off == DW - 1) ? 0 : m_off + 1;
      m_hold = 2;
    end else if (m_hold > 0) m_hold--;
    m_sd = s;
    check({req, " dout"}, 32'(dout), 32'(e));
    check({req, " pat_hit"}, 32'(pat_hit), 32'(eh));
  endtask

  task automatic do_reset();
    rst = 1'b1; slip = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2 dout after reset", 32'(dout), 32'h0);
    check("R2 pat_hit after reset", 32'(pat_hit), 32'h0);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic t_pass();
    logic [DW-1:0] v [6] = '{16'h1234, 16'hABCD, 16'h0001, 16'h8000, 16'hFFFF, 16'h5A5A};
    do_reset();
    foreach (v[i]) begin
      cyc(v[i], 0, "R1 pass");
      check("R1 offset0 repeat", 32'(dout), 32'(v[i]));
    end
  endtask

  task automatic t_slip_one();
    logic [DW-1:0] c = 16'h00F1;
    do_reset();
    cyc(c, 0, "R3"); cyc(c, 1, "R3"); cyc(c, 0, "R3"); cyc(c, 0, "R3");
    check("R3 one slip rotates", 32'(dout), 32'(rotl(c, 1)));
    cyc(16'h1357, 0, "R1 mixed"); cyc(16'h9BDF, 0, "R1 mixed");
  endtask

  task automatic t_hold();
    logic [DW-1:0] c = 16'h0C3A;
    do_reset();
    cyc(c, 0, "R4");
    for (int i = 0; i < 8; i++) cyc(c, 1, "R4 held");
    cyc(c, 0, "R4"); cyc(c, 0, "R4");
    check("R4 held input one slip", 32'(dout), 32'(rotl(c, 1)));
  endtask

  task automatic t_lockout();
    logic [DW-1:0] c = 16'h0007;
    do_reset();
    cyc(c, 0, "R5");
    cyc(c, 1, "R5"); cyc(c, 0, "R5"); cyc(c, 1, "R5 ignored"); cyc(c, 0, "R5"); cyc(c, 0, "R5");
    check("R5 second pulse ignored", 32'(dout), 32'(rotl(c, 1)));
    cyc(c, 1, "R5 after window"); cyc(c, 0, "R5"); cyc(c, 0, "R5");
    check("R5 pulse after window taken", 32'(dout), 32'(rotl(c, 2)));
  endtask

  task automatic t_wrap();
    logic [DW-1:0] c = 16'h2F01;
    do_reset();
    cyc(c, 0, "R6");
    for (int i = 1; i <= DW; i++) begin
      cyc(c, 1, "R6"); cyc(c, 0, "R6"); cyc(c, 0, "R6");
      if (i == DW - 1) check("R6 last offset", 32'(dout), 32'(rotl(c, DW - 1)));
    end
    check("R6 wrap to zero", 32'(dout), 32'(c));
  endtask

  task automatic t_pat_one();
    logic [DW-1:0] p = 16'h28F6;
    logic [DW-1:0] c;
    int found = -1;
    do_reset();
    cfg_two = 1'b0;
    cfg_pattern = {16'h0000, p};
    c = rotl(p, DW - 5);
    cyc(c, 0, "R7"); cyc(c, 0, "R7");
    for (int n = 0; n < DW && found < 0; n++) begin
      if (pat_hit) found = n;
      else begin
        cyc(c, 1, "R7 scan"); cyc(c, 0, "R7 scan"); cyc(c, 0, "R7 scan");
      end
    end
    check("R7 slips until match", 32'(found), 32'd5);
    check("R7 aligned word", 32'(dout), 32'(p));
    cyc(16'h0000, 0, "R7 drop"); cyc(16'h0000, 0, "R7 drop");
    check("R7 flag falls", 32'(pat_hit), 32'h0);
  endtask

  task automatic t_pat_two();
    logic [2*DW-1:0] s = {16'h2828, 16'hF6F6};
    logic [2*DW-1:0] r;
    logic [DW-1:0] w [2];
    int ph = 0;
    int found = -1;
    do_reset();
    cfg_two = 1'b1;
    cfg_pattern = s;
    r = (s >> 3) | (s << (2*DW - 3));
    w[0] = r[DW-1:0]; w[1] = r[2*DW-1:DW];
    cyc(w[0], 0, "R8"); cyc(w[1], 0, "R8");
    for (int n = 0; n < DW && found < 0; n++) begin
      for (int j = 0; j < 5; j++) begin
        cyc(w[ph], (j == 0), "R8 scan");
        ph ^= 1;
        if (pat_hit && found < 0) found = n + 1;
      end
    end
    check("R8 slips until pair", 32'(found), 32'd3);
    cfg_pattern = {16'h2828, 16'h1111};
    cyc(w[ph], 0, "R8 half only"); ph ^= 1;
    cyc(w[ph], 0, "R8 half only");
    check("R8 no hit on half", 32'(pat_hit), 32'h0);
    cfg_two = 1'b0;
  endtask

  task automatic t_reset_mid();
    logic [DW-1:0] c = 16'h0F35;
    do_reset();
    cyc(c, 0, "R2"); cyc(c, 1, "R2"); cyc(c, 0, "R2"); cyc(c, 0, "R2");
    do_reset();
    cyc(c, 0, "R2 after mid reset");
    check("R2 offset back to zero", 32'(dout), 32'(c));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    do_reset();
    t_pass();
    t_slip_one();
    t_hold();
    t_lockout();
    t_wrap();
    t_pat_one();
    t_pat_two();
    t_reset_mid();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

endmodule